// File: doc/BRIEF.md
# Conditional return-from-interrupt unit

This block keeps the instruction pointer and the interrupt-in-service bit of a small processor core, together with a hardware return-address stack. On interrupt entry it saves the current instruction pointer on the stack, jumps to a fixed vector and marks the core as in service. On a return-from-interrupt operation it tests a selected status condition (carry, zero, sign, their complements, or none at all). When the condition holds and the stack has an entry, it pops that entry into the instruction pointer and clears the in-service bit.

A return whose condition fails has no side effect. The stack and the in-service bit stay as they were, and the pointer moves on by one like any non-branching instruction. The zero condition comes straight from the accumulator value, so no separate flag register is needed. A sticky underflow flag marks a return that should have popped an empty stack.

Top module: `reti_unit`

## Requirements
- R1: After reset, ip_o equals RESET_IP (0 by default), ins_o is 0, depth_o is 0 and underflow_o is 0.
- R2: The 3-bit selector cond_sel_i is decoded as follows. 0 is always true. 1 is true when carry_i=1. 2 is true when carry_i=0. 3 is true when acc_i is zero. 4 is true when acc_i is nonzero. 5 is true when sign_i=1. 6 and 7 are never true.
- R3: A return whose condition is true, issued with the stack non-empty, raises taken_o in the same cycle. At the next edge it loads ip_o with the top stack entry, clears ins_o and lowers depth_o by one.
- R4: A return whose condition is false keeps taken_o low. It leaves depth_o, the stack contents and ins_o unchanged, and sets ip_o to ip_o+1.
- R5: The zero condition is computed from every bit of acc_i, with no registered flag in between.
- R6: irq_i with the stack not full pushes the current ip_o, loads ip_o with VECTOR, sets ins_o and raises depth_o by one.
- R7: irq_i with depth_o equal to DEPTH is refused. ip_o, ins_o and depth_o are unchanged, and no other operation runs in that cycle.
- R8: Returns give back the saved addresses in last-in, first-out order.
- R9: A return with a true condition on an empty stack sets underflow_o, which then stays set until reset. ip_o advances by one, and ins_o and depth_o are unchanged.
- R10: Only one operation runs per cycle. irq_i has priority over ret_i, and ret_i has priority over step_i. With none of them asserted, all state holds.
- R11: step_i alone, and every non-taken return, advance ip_o by one modulo 2^IP_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 1 | Interrupt entry: push ip, jump to vector |
| ret_i | input | 1 | Return-from-interrupt operation |
| step_i | input | 1 | Non-branching instruction completes |
| cond_sel_i | input | 3 | Return condition selector |
| carry_i | input | 1 | Carry flag |
| sign_i | input | 1 | Sign flag |
| acc_i | input | ACC_W | Accumulator value |
| ip_o | output | IP_W | Instruction pointer |
| ins_o | output | 1 | Interrupt-in-service bit |
| depth_o | output | $clog2(DEPTH+1) | Stack occupancy |
| underflow_o | output | 1 | Sticky pop-on-empty error |
| taken_o | output | 1 | Return is executed this cycle |

## Verification
The bench builds the unit with IP_W=8, ACC_W=4, DEPTH=4 and VECTOR=8'hFF. The narrow accumulator lets the bench sweep all eight selectors against every carry, sign and accumulator combination, which covers every zero and nonzero case. Putting the vector at the top of the address space means that each failed return wraps the pointer to zero, so modular advance is checked on every false condition. A four-entry stack can be filled in a few cycles, which puts the refused entry, the LIFO order and the empty-stack pop all within a short run.

// File: rtl/reti_pkg.sv
package reti_pkg;

  typedef enum logic [2:0] {
    SEL_ALWAYS = 3'd0,
    SEL_CARRY  = 3'd1,
    SEL_NCARRY = 3'd2,
    SEL_ZERO   = 3'd3,
    SEL_NZERO  = 3'd4,
    SEL_SIGN   = 3'd5,
    SEL_RSV6   = 3'd6,
    SEL_RSV7   = 3'd7
  } ret_sel_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_IRQ  = 2'd1,
    OP_RET  = 2'd2,
    OP_STEP = 2'd3
  } op_e;

endpackage

// File: rtl/reti_cond.sv
module reti_cond
  import reti_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic [2:0]       sel_i,
  input  logic             carry_i,
  input  logic             sign_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic             zero_o,
  output logic             cond_ok_o
);

  ret_sel_e sel;

  assign sel    = ret_sel_e'(sel_i);
  assign zero_o = ~|acc_i;

  always_comb begin
    unique case (sel)
      SEL_ALWAYS: cond_ok_o = 1'b1;
      SEL_CARRY:  cond_ok_o = carry_i;
      SEL_NCARRY: cond_ok_o = ~carry_i;
      SEL_ZERO:   cond_ok_o = zero_o;
      SEL_NZERO:  cond_ok_o = ~zero_o;
      SEL_SIGN:   cond_ok_o = sign_i;
      default:    cond_ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/reti_stack.sv
module reti_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     din_i,
  output logic [W-1:0]     top_o,
  output logic [PTR_W-1:0] depth_o,
  output logic             empty_o,
  output logic             full_o
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] cnt;
  logic [IDX_W-1:0] top_idx;

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == PTR_W'(DEPTH));
  assign depth_o = cnt;
  assign top_idx = IDX_W'(cnt - 1'b1);
  assign top_o   = empty_o ? '0 : mem[top_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem[g] <= '0;
      else if (push_i && cnt == PTR_W'(g))     mem[g] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt <= '0;
    else if (push_i && !pop_i) cnt <= cnt + 1'b1;
    else if (pop_i && !push_i) cnt <= cnt - 1'b1;
  end

  p_pop_nonempty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_push_room_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_depth_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= PTR_W'(DEPTH));
  p_push_grows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> cnt == $past(cnt) + 1'b1);
  p_pop_shrinks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/reti_seq.sv
module reti_seq
  import reti_pkg::*;
#(
  parameter int          IP_W     = 16,
  parameter logic [IP_W-1:0] VECTOR   = '0,
  parameter logic [IP_W-1:0] RESET_IP = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            irq_i,
  input  logic            ret_i,
  input  logic            step_i,
  input  logic            cond_ok_i,
  input  logic            empty_i,
  input  logic            full_i,
  input  logic [IP_W-1:0] top_i,
  output logic            push_o,
  output logic            pop_o,
  output logic [IP_W-1:0] ip_o,
  output logic            ins_o,
  output logic            underflow_o,
  output logic            taken_o
);

  op_e op;
  logic uflow_hit;

  always_comb begin
    if (irq_i)       op = OP_IRQ;
    else if (ret_i)  op = OP_RET;
    else if (step_i) op = OP_STEP;
    else             op = OP_NONE;
  end

  assign push_o    = (op == OP_IRQ) && !full_i;
  assign taken_o   = (op == OP_RET) && cond_ok_i && !empty_i;
  assign uflow_hit = (op == OP_RET) && cond_ok_i && empty_i;
  assign pop_o     = taken_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_o <= RESET_IP;
    end else begin
      unique case (op)
        OP_IRQ:  if (!full_i) ip_o <= VECTOR;
        OP_RET:  ip_o <= taken_o ? top_i : ip_o + 1'b1;
        OP_STEP: ip_o <= ip_o + 1'b1;
        default: ip_o <= ip_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ins_o <= 1'b0;
    else if (push_o)  ins_o <= 1'b1;
    else if (taken_o) ins_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        underflow_o <= 1'b0;
    else if (uflow_hit) underflow_o <= 1'b1;
  end

  p_taken_clears_ins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |=> !ins_o);
  p_taken_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |=> ip_o == $past(top_i));
  p_fail_keeps_ins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !irq_i && !cond_ok_i) |=> ins_o == $past(ins_o));
  p_fail_advances_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !irq_i && !cond_ok_i) |=> ip_o == $past(ip_o) + 1'b1);
  p_uflow_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);
  p_irq_vector_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !full_i) |=> (ip_o == VECTOR) && ins_o);
  p_irq_refused_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && full_i) |=> $stable(ip_o) && $stable(ins_o));

endmodule

// File: rtl/reti_unit.sv
module reti_unit
  import reti_pkg::*;
#(
  parameter int              IP_W     = 16,
  parameter int              ACC_W    = 16,
  parameter int              DEPTH    = 8,
  parameter logic [IP_W-1:0] VECTOR   = 16'h0100,
  parameter logic [IP_W-1:0] RESET_IP = '0,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_i,
  input  logic             ret_i,
  input  logic             step_i,
  input  logic [2:0]       cond_sel_i,
  input  logic             carry_i,
  input  logic             sign_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [IP_W-1:0]  ip_o,
  output logic             ins_o,
  output logic [PTR_W-1:0] depth_o,
  output logic             underflow_o,
  output logic             taken_o
);

  logic            zero;
  logic            cond_ok;
  logic            push, pop, empty, full;
  logic [IP_W-1:0] top;

  reti_cond #(.ACC_W(ACC_W)) u_cond (
    .sel_i    (cond_sel_i),
    .carry_i  (carry_i),
    .sign_i   (sign_i),
    .acc_i    (acc_i),
    .zero_o   (zero),
    .cond_ok_o(cond_ok)
  );

  reti_stack #(.DEPTH(DEPTH), .W(IP_W)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .din_i  (ip_o),
    .top_o  (top),
    .depth_o(depth_o),
    .empty_o(empty),
    .full_o (full)
  );

  reti_seq #(.IP_W(IP_W), .VECTOR(VECTOR), .RESET_IP(RESET_IP)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .ret_i      (ret_i),
    .step_i     (step_i),
    .cond_ok_i  (cond_ok),
    .empty_i    (empty),
    .full_i     (full),
    .top_i      (top),
    .push_o     (push),
    .pop_o      (pop),
    .ip_o       (ip_o),
    .ins_o      (ins_o),
    .underflow_o(underflow_o),
    .taken_o    (taken_o)
  );

  p_zero_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !irq_i && cond_sel_i == 3'd3 && acc_i != '0) |-> !taken_o);
  p_fail_keeps_depth_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !irq_i && !taken_o) |=> $stable(depth_o));
  p_idle_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_i && !ret_i && !step_i) |=> $stable(ip_o) && $stable(depth_o) && $stable(ins_o));

endmodule

// File: tb/reti_unit_test.sv
`timescale 1ns/1ps
module reti_unit_test;

  localparam int IP_W  = 8;
  localparam int ACC_W = 4;
  localparam int DEPTH = 4;
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam logic [7:0] VEC = 8'hFF;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             irq = 1'b0, ret = 1'b0, step = 1'b0;
  logic [2:0]       sel = '0;
  logic             carry = 1'b0, sign = 1'b0;
  logic [ACC_W-1:0] acc = '0;
  logic [IP_W-1:0]  ip;
  logic             ins;
  logic [PTR_W-1:0] depth;
  logic             uflow;
  logic             taken;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit tk;
  int ip_e;
  int saved [1:4];

  reti_unit #(
    .IP_W(IP_W), .ACC_W(ACC_W), .DEPTH(DEPTH), .VECTOR(VEC), .RESET_IP(8'h00)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .ret_i(ret), .step_i(step),
    .cond_sel_i(sel), .carry_i(carry), .sign_i(sign), .acc_i(acc),
    .ip_o(ip), .ins_o(ins), .depth_o(depth), .underflow_o(uflow), .taken_o(taken)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle of inputs at the negedge, capture taken_o, return after the edge
  task automatic cyc(input bit i, input bit r, input bit s, input int sl,
                     input bit c, input bit sg, input int a);
    irq = i; ret = r; step = s; sel = 3'(sl); carry = c; sign = sg; acc = ACC_W'(a);
    #1 tk = taken;
    @(negedge clk);
    irq = 1'b0; ret = 1'b0; step = 1'b0;
  endtask

  function automatic bit cond_exp(int sl, bit c, bit sg, int a);
    case (sl)
      0: return 1'b1;
      1: return c;
      2: return !c;
      3: return a == 0;
      4: return a != 0;
      5: return sg;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 ip", ip, 0);
    chk("R1 ins", ins, 0);
    chk("R1 depth", depth, 0);
    chk("R1 underflow", uflow, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    ip_e = 0;

    // R2 R3 R4 R5 R6 R11: full sweep of selector x carry x sign x accumulator
    for (int sl = 0; sl < 8; sl++)
      for (int c = 0; c < 2; c++)
        for (int sg = 0; sg < 2; sg++)
          for (int a = 0; a < 16; a++) begin
            bit e;
            int x;
            cyc(0, 0, 1, 0, 0, 0, 0);
            ip_e = (ip_e + 1) % 256;
            x = ip_e;
            chk("R11 step", ip, x);
            cyc(1, 0, 0, 0, 0, 0, 0);
            chk("R6 vector", ip, VEC);
            chk("R6 ins", ins, 1);
            chk("R6 depth", depth, 1);
            e = cond_exp(sl, c[0], sg[0], a);
            cyc(0, 1, 0, sl, c[0], sg[0], a);
            chk("R2/R5 taken", tk, e);
            if (e) begin
              chk("R3 ip", ip, x);
              chk("R3 ins", ins, 0);
              chk("R3 depth", depth, 0);
            end else begin
              chk("R4/R11 ip", ip, (VEC + 1) % 256);
              chk("R4 ins", ins, 1);
              chk("R4 depth", depth, 1);
              cyc(0, 1, 0, 0, 0, 0, 0);
              chk("R4 stack kept", ip, x);
              chk("R4 ins cleared later", ins, 0);
            end
            ip_e = x;
          end

    // R6 R7 R8: fill the stack with distinct addresses, refuse a fifth entry, pop LIFO
    for (int k = 1; k <= 4; k++) begin
      for (int j = 0; j < k; j++) begin
        cyc(0, 0, 1, 0, 0, 0, 0);
        ip_e = (ip_e + 1) % 256;
      end
      saved[k] = ip_e;
      cyc(1, 0, 0, 0, 0, 0, 0);
      ip_e = VEC;
      chk("R6 fill depth", depth, k);
    end
    cyc(0, 0, 1, 0, 0, 0, 0);
    ip_e = (ip_e + 1) % 256;
    cyc(1, 1, 1, 0, 0, 0, 0);
    chk("R7 refused ip", ip, ip_e);
    chk("R7 refused depth", depth, 4);
    chk("R7 refused ins", ins, 1);
    for (int k = 4; k >= 1; k--) begin
      cyc(0, 1, 0, 0, 0, 0, 0);
      chk("R8 lifo ip", ip, saved[k]);
      chk("R8 lifo depth", depth, k - 1);
    end
    ip_e = saved[1];
    chk("R3 ins after last pop", ins, 0);

    // R10 priority
    cyc(1, 1, 1, 0, 0, 0, 0);
    chk("R10 irq wins ip", ip, VEC);
    chk("R10 irq wins depth", depth, 1);
    chk("R10 irq wins taken", tk, 0);
    cyc(0, 1, 1, 0, 0, 0, 0);
    chk("R10 ret over step", ip, saved[1]);
    chk("R10 ret over step depth", depth, 0);
    cyc(0, 0, 0, 0, 1, 1, 0);
    chk("R10 idle ip", ip, saved[1]);
    chk("R10 idle ins", ins, 0);
    ip_e = saved[1];

    // R9 underflow: false condition on empty first, then a true one
    cyc(0, 1, 0, 6, 1, 1, 0);
    chk("R9 false on empty no flag", uflow, 0);
    chk("R9 false on empty ip", ip, (ip_e + 1) % 256);
    ip_e = (ip_e + 1) % 256;
    cyc(0, 1, 0, 0, 0, 0, 0);
    chk("R9 flag", uflow, 1);
    chk("R9 taken", tk, 0);
    chk("R9 ip", ip, (ip_e + 1) % 256);
    chk("R9 ins", ins, 0);
    chk("R9 depth", depth, 0);
    cyc(0, 0, 1, 0, 0, 0, 0);
    chk("R9 sticky", uflow, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule